// File: doc/BRIEF.md
# Oscillator Frequency Probe

The probe finds out which of four supported crystal frequencies is fitted to a chip. Software writes a trigger word. The block then waits for the next strobe of the slow 32.768 kHz reference and counts oscillator strobes across a window of a chosen number of whole reference periods. When the window closes, the block sorts the count into one of four tolerance bands. It then stores the matching 2-bit frequency code in the oscillator control word, or raises a sticky error flag if the count falls in no band.

The oscillator and the reference arrive as single-cycle enable strobes in the system clock domain. Software starts a run, polls the busy flag, and reads the count, the error flag and the frequency code.

Top module: `osc_freq_probe`

## Requirements
- R1: A write with `ctl_wdata_i[31]` set, while idle, starts a measurement. A write with bit 31 clear leaves the status and control outputs unchanged.
- R2: `status_o[31]` (busy) is set from the cycle after an accepted trigger. It clears in the same cycle that the result is stored.
- R3: `status_o[15:0]` clears on an accepted trigger. It then counts oscillator strobes that fall after the first reference strobe following the trigger, up to and including the strobe that closes the window. Oscillator strobes that arrive before that first reference strobe are not counted.
- R4: `ctl_wdata_i[15:0]` sets the window length in reference periods, so a length of W with one oscillator strobe per cycle gives a count of W times the reference period. A length of 0 counts as 1.
- R5: A count within ±3 (inclusive) of 732, 794, 1172 or 1587 writes code 2, 0, 1 or 3 into `osc_ctrl_o[31:30]`. These counts stand for 12, 13, 19.2 and 26 MHz. All other bits of `osc_ctrl_o` are zero.
- R6: A count in no band sets the error flag `status_o[30]` and leaves `osc_ctrl_o` unchanged. The flag stays set until the next accepted trigger clears it.
- R7: A trigger written while busy is ignored. The current window, its length and its count go on unchanged.
- R8: The count saturates at 0xFFFF and does not wrap.
- R9: After reset, `status_o` and `osc_ctrl_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_tick_i | input | 1 | One-cycle strobe per oscillator period |
| ref_tick_i | input | 1 | One-cycle strobe per slow reference period |
| ctl_wr_i | input | 1 | Trigger word write strobe |
| ctl_wdata_i | input | 32 | Trigger word: bit 31 start, bits 15:0 window length |
| status_o | output | 32 | Bit 31 busy, bit 30 error, bits 15:0 count |
| osc_ctrl_o | output | 32 | Oscillator control word, code in bits 31:30 |

## Verification
The assertions assume that each strobe lasts one cycle and that writes come in as single-cycle pulses on `ctl_wr_i`. They also assume that the trigger word is only sampled while `ctl_wr_i` is high. Under those conditions the count can rise by at most one per cycle and never falls during a run. The stimulus generates the reference as a periodic one-cycle pulse and the oscillator as a pulse every cycle, every other cycle, or on a fixed pseudo-random pattern. It drives every write for exactly one cycle, including the write that lands while the block is busy.

// File: rtl/osc_probe_pkg.sv
package osc_probe_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_COUNT, ST_DONE} probe_state_e;

  localparam int NUM_BANDS = 4;
  localparam int BAND_TOL  = 3;

  function automatic int band_center(input int idx);
    case (idx)
      0:       return 732;
      1:       return 794;
      2:       return 1172;
      default: return 1587;
    endcase
  endfunction

  function automatic logic [1:0] band_code(input int idx);
    case (idx)
      0:       return 2'd2;
      1:       return 2'd0;
      2:       return 2'd1;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/osc_sat_counter.sv
module osc_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/osc_window_timer.sv
module osc_window_timer #(
  parameter int WIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIN_W-1:0] len_i,
  input  logic             tick_i,
  output logic             last_o
);
  logic [WIN_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (load_i) rem_q <= (len_i == '0) ? WIN_W'(1) : len_i;
    else if (tick_i && rem_q > WIN_W'(1)) rem_q <= rem_q - 1'b1;
  end

  // remaining period is the final one
  assign last_o = (rem_q <= WIN_W'(1));
endmodule

// File: rtl/osc_band_classifier.sv
module osc_band_classifier
  import osc_probe_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic             hit_o,
  output logic [1:0]       code_o
);
  logic [NUM_BANDS-1:0] in_band;
  logic [1:0]           code_by [NUM_BANDS];

  for (genvar g = 0; g < NUM_BANDS; g++) begin : g_band
    assign in_band[g] = (int'(cnt_i) >= band_center(g) - BAND_TOL) &&
                        (int'(cnt_i) <= band_center(g) + BAND_TOL);
    assign code_by[g] = in_band[g] ? band_code(g) : 2'd0;
  end

  always_comb begin
    code_o = 2'd0;
    for (int i = 0; i < NUM_BANDS; i++) code_o = code_o | code_by[i];
  end

  assign hit_o = |in_band;
endmodule

// File: rtl/osc_freq_probe.sv
module osc_freq_probe
  import osc_probe_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int WIN_W    = 16,
  parameter int TRIG_BIT = 31
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        osc_tick_i,
  input  logic        ref_tick_i,
  input  logic        ctl_wr_i,
  input  logic [31:0] ctl_wdata_i,
  output logic [31:0] status_o,
  output logic [31:0] osc_ctrl_o
);
  localparam int BUSY_BIT = 31;
  localparam int ERR_BIT  = 30;

  probe_state_e     state_q, state_d;
  logic             start, in_count, win_last, hit, err_q;
  logic [1:0]       code_q, hit_code;
  logic [CNT_W-1:0] cnt;
  logic             unused_wdata;

  assign unused_wdata = ^ctl_wdata_i[TRIG_BIT-1:WIN_W];

  assign start    = (state_q == ST_IDLE) && ctl_wr_i && ctl_wdata_i[TRIG_BIT];
  assign in_count = (state_q == ST_COUNT);

  osc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (start),
    .inc_i (in_count && osc_tick_i),
    .cnt_o (cnt)
  );

  osc_window_timer #(.WIN_W(WIN_W)) u_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(start),
    .len_i (ctl_wdata_i[WIN_W-1:0]),
    .tick_i(in_count && ref_tick_i),
    .last_o(win_last)
  );

  osc_band_classifier #(.CNT_W(CNT_W)) u_cls (
    .cnt_i (cnt),
    .hit_o (hit),
    .code_o(hit_code)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_ARM;
      ST_ARM:   if (ref_tick_i) state_d = ST_COUNT;
      ST_COUNT: if (ref_tick_i && win_last) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= 2'd0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start) err_q <= 1'b0;
      if (state_q == ST_DONE) begin
        if (hit) code_q <= hit_code;
        else     err_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[BUSY_BIT] = (state_q != ST_IDLE);
    status_o[ERR_BIT]  = err_q;
    status_o[CNT_W-1:0] = cnt;
  end

  assign osc_ctrl_o = {code_q, 30'd0};
endmodule

// File: rtl/osc_freq_probe_chk.sv
module osc_freq_probe_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctl_wr_i,
  input logic [31:0] ctl_wdata_i,
  input logic [31:0] status_o,
  input logic [31:0] osc_ctrl_o
);
  logic        busy, err;
  logic [15:0] cnt;
  assign busy = status_o[31];
  assign err  = status_o[30];
  assign cnt  = status_o[15:0];

  p_start_needs_trigger_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(ctl_wr_i && ctl_wdata_i[31]));

  p_count_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> (cnt - $past(cnt)) <= 16'd1);

  p_code_idle_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && $past(!busy)) |-> $stable(osc_ctrl_o));

  p_code_low_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_ctrl_o[29:0] == 30'd0);

  p_err_keeps_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err) |-> $stable(osc_ctrl_o));

  p_busy_no_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> cnt >= $past(cnt));

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cnt == 16'hFFFF) |=> cnt == 16'hFFFF);
endmodule

bind osc_freq_probe osc_freq_probe_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctl_wr_i   (ctl_wr_i),
  .ctl_wdata_i(ctl_wdata_i),
  .status_o   (status_o),
  .osc_ctrl_o (osc_ctrl_o)
);

// File: tb/sim_osc_freq_probe.sv
`timescale 1ns/1ps
module sim_osc_freq_probe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_tick = 1'b0, ref_tick = 1'b0, ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] status, osc_ctrl;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int ref_period = 0, osc_mode = 0;
  bit done = 0;

  // behavioural model
  int m_st = 0, m_cnt = 0, m_win = 0, m_code = 0, m_err = 0;

  always #4 clk = ~clk;

  osc_freq_probe u0 (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(osc_tick), .ref_tick_i(ref_tick),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata), .status_o(status), .osc_ctrl_o(osc_ctrl)
  );

  task automatic check(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int classify(input int c);
    if (c >= 729 && c <= 735)   return 2;
    if (c >= 791 && c <= 797)   return 0;
    if (c >= 1169 && c <= 1175) return 1;
    if (c >= 1584 && c <= 1590) return 3;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_win = 0; m_code = 0; m_err = 0;
    end else begin
      case (m_st)
        0: if (ctl_wr && ctl_wdata[31]) begin
             m_cnt = 0; m_err = 0; m_st = 1;
             m_win = (ctl_wdata[15:0] == 0) ? 1 : int'(ctl_wdata[15:0]);
           end
        1: if (ref_tick) m_st = 2;
        2: begin
             if (osc_tick && m_cnt < 65535) m_cnt++;
             if (ref_tick) begin
               if (m_win <= 1) m_st = 3; else m_win--;
             end
           end
        default: begin
             if (classify(m_cnt) >= 0) m_code = classify(m_cnt); else m_err = 1;
             m_st = 0;
           end
      endcase
    end
  end

  // stimulus generators and per-cycle comparison
  initial begin
    int rc = 0;
    int lfsr = 32'h1d;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        check(int'(status[31]), int'(m_st != 0), "R2 busy");
        check(int'(status[30]), m_err, "R6 error flag");
        check(int'(status[15:0]), m_cnt, "R3 count");
        check(int'(osc_ctrl[31:30]), m_code, "R5 code");
        check(int'(osc_ctrl[29:0]), 0, "R5 spare bits");
      end
      if (ref_period > 0) begin
        rc = (rc + 1 >= ref_period) ? 0 : rc + 1;
        ref_tick = (rc == 0);
      end else ref_tick = 1'b0;
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      case (osc_mode)
        0: osc_tick = 1'b1;
        1: osc_tick = ~osc_tick;
        default: osc_tick = lfsr[0];
      endcase
    end
  end

  task automatic write_ctl(input logic [31:0] w);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = w;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (status[31]) @(negedge clk);
    #1;
  endtask

  task automatic measure(input int win, input int q, input int mode);
    ref_period = q; osc_mode = mode;
    write_ctl(32'h8000_0000 | win);
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(int'(status), 0, "R9 reset status");
    check(int'(osc_ctrl), 0, "R9 reset ctrl");
    rst_n = 1'b1;
    ref_period = 50;
    write_ctl(32'h0000_0001);
    repeat (120) @(negedge clk);
    #1;
    check(int'(status[31]), 0, "R1 no start without bit 31");
    // band centres
    measure(1, 732, 0);  check(int'(osc_ctrl[31:30]), 2, "R5 12MHz");
    measure(1, 794, 0);  check(int'(osc_ctrl[31:30]), 0, "R5 13MHz");
    measure(1, 1172, 0); check(int'(osc_ctrl[31:30]), 1, "R5 19.2MHz");
    measure(1, 1587, 0); check(int'(osc_ctrl[31:30]), 3, "R5 26MHz");
    check(int'(status[15:0]), 1587, "R3 count value");
    // band edges
    measure(1, 735, 0);  check(int'(osc_ctrl[31:30]), 2, "R5 upper edge");
    check(int'(status[30]), 0, "R5 no error at edge");
    measure(1, 736, 0);  check(int'(status[30]), 1, "R6 above band");
    check(int'(osc_ctrl[31:30]), 2, "R6 code kept");
    measure(1, 728, 0);  check(int'(status[30]), 1, "R6 below band");
    measure(1, 729, 0);  check(int'(status[30]), 0, "R6 cleared by trigger");
    check(int'(osc_ctrl[31:30]), 2, "R5 lower edge");
    // window length
    measure(2, 397, 0);  check(int'(status[15:0]), 794, "R4 two periods");
    check(int'(osc_ctrl[31:30]), 0, "R4 code");
    measure(0, 1172, 0); check(int'(status[15:0]), 1172, "R4 zero as one");
    // other oscillator patterns
    measure(1, 3174, 1); check(int'(osc_ctrl[31:30]), 3, "R3 half-rate osc");
    measure(3, 500, 2);  check(int'(status[31]), 0, "R3 pseudo-random osc");
    // trigger while busy
    ref_period = 1587; osc_mode = 0;
    write_ctl(32'h8000_0001);
    repeat (700) @(negedge clk);
    write_ctl(32'h8000_0005);
    wait_idle();
    check(int'(status[15:0]), 1587, "R7 busy trigger ignored");
    check(int'(osc_ctrl[31:30]), 3, "R7 code");
    // saturation
    measure(70, 1000, 0);
    check(int'(status[15:0]), 65535, "R8 saturate");
    check(int'(status[30]), 1, "R8 error on saturated count");
    repeat (5) @(negedge clk);
    done = 1;
  end

  initial begin
    while (!done && cyc < 190000) @(negedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule